// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Fetch Squash

This block settles conditional branches while they sit in the decode stage of a five-stage pipeline. Fetch always runs sequentially, so the pipeline bets that no branch is taken. The block takes the two branch operands after the forwarding multiplexers, the incremented PC of the branch, its sign-extended offset and a decode of the branch kind (branch-if-equal or branch-if-not-equal). It compares the operands without the main ALU. It computes the target on its own adder. When the branch goes the other way from the bet, it steers the PC multiplexer to the target and clears the fetch/decode pipeline register. The cost of a wrong bet is therefore one cycle.

The fetch/decode register is kept inside the block so that squash and hold act on it directly. A branch that needs the result of a load still in the execute or memory stage cannot be settled yet. The block raises a stall, holds the fetch/decode register, and tries again on the next cycle. A small controller follows the pipeline through three named states:
- `ST_RUN`: normal issue.
- `ST_LDWAIT`: a branch is held behind a load.
- `ST_BUBBLE`: decode holds the squashed nop.

Every state moves by the same three transitions:
- `stall`: go to `ST_LDWAIT`.
- `redirect`: a taken branch, go to `ST_BUBBLE`.
- `proceed`: anything else, go to `ST_RUN`.

Top module: `id_branch_resolve`

## Requirements
- R1: With `is_beq_i` high and no stall, `taken_o` is 1 exactly when `opnd_a_i` and `opnd_b_i` are equal in all bits. A difference in only the most significant bit, or in only bit 0, gives 0.
- R2: With `is_bne_i` high and no stall, `taken_o` is 1 exactly when the two operands differ in at least one bit.
- R3: `target_o` always equals `pc_plus4_i + (imm_sext_i << 2)` modulo 2^32. This includes negative offsets.
- R4: `pc_sel_o` and `if_flush_o` are 1 in the same cycle as `taken_o` and are 0 whenever `taken_o` is 0. A value of 1 on `pc_sel_o` selects `target_o`, and 0 keeps sequential fetch.
- R5: On the clock edge after `if_flush_o` is 1, `ifid_instr_o` and `ifid_pc4_o` both become all zeros.
- R6: A branch stalls when a nonzero `rs_idx_i` or `rt_idx_i` matches the destination of a load in the execute stage (`ex_load_i`, `ex_dest_i`) or in the memory stage (`mem_load_i`, `mem_dest_i`). While `stall_o` is 1, `taken_o` and `if_flush_o` are 0 and the fetch/decode register keeps its value.
- R7: Register index 0 never causes a stall. A producer in the execute or memory stage that is not a load never causes a stall.
- R8: In the cycle after a flush, a branch decode is ignored: `taken_o` and `stall_o` stay 0.
- R9: After reset, `ifid_instr_o` and `ifid_pc4_o` are 0 and `taken_o`, `stall_o` and `if_flush_o` are 0.
- R10: With neither branch decode high, `taken_o` and `stall_o` are 0 even if a load destination matches a source index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_instr_i | input | 32 | Instruction from fetch |
| fetch_pc4_i | input | 32 | Incremented PC from fetch |
| is_beq_i | input | 1 | Decode: branch if equal |
| is_bne_i | input | 1 | Decode: branch if not equal |
| opnd_a_i | input | 32 | First branch operand after forwarding |
| opnd_b_i | input | 32 | Second branch operand after forwarding |
| pc_plus4_i | input | 32 | Incremented PC of the branch in decode |
| imm_sext_i | input | 32 | Sign-extended branch offset in words |
| rs_idx_i | input | 5 | First source register index |
| rt_idx_i | input | 5 | Second source register index |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| ex_dest_i | input | 5 | Execute-stage destination register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| mem_dest_i | input | 5 | Memory-stage destination register |
| taken_o | output | 1 | Branch resolved taken this cycle |
| target_o | output | 32 | Branch target address |
| pc_sel_o | output | 1 | 1 selects the target for the next PC |
| if_flush_o | output | 1 | Squash the instruction now being fetched |
| stall_o | output | 1 | Hold PC and fetch/decode register |
| ifid_instr_o | output | 32 | Fetch/decode register: instruction |
| ifid_pc4_o | output | 32 | Fetch/decode register: incremented PC |

## Verification
The assertions assume that at most one of `is_beq_i` and `is_bne_i` is high in a cycle. They also assume that the decode inputs describe the instruction now in the fetch/decode register, so a squashed bubble never carries a real branch. The stimulus drives a single branch kind per cycle and changes inputs only on the falling edge. It moves a load from the execute stage to the memory stage in consecutive cycles the way a real pipeline would. It still presents a branch decode in the bubble cycle on purpose, to show that the block ignores it.

// File: rtl/br_pkg.sv
package br_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_LDWAIT = 2'd1,
        ST_BUBBLE = 2'd2
    } br_state_e;

    localparam int unsigned N_LOAD_SLOTS = 2;

endpackage

// File: rtl/br_compare.sv
module br_compare #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            bne_i,
    output logic            cond_o
);
    logic [XLEN-1:0] diff;
    logic            same;

    assign diff   = a_i ^ b_i;
    assign same   = ~(|diff);
    assign cond_o = bne_i ? ~same : same;

    // R1
    eq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bne_i && (a_i == b_i)) |-> cond_o);
    // R2
    ne_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bne_i && (a_i != b_i)) |-> cond_o);
endmodule

// File: rtl/br_target.sv
module br_target #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned SHIFT = 2
) (
    input  logic [XLEN-1:0] pc4_i,
    input  logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] target_o
);
    logic [XLEN-1:0] offs;

    assign offs     = {imm_i[XLEN-SHIFT-1:0], {SHIFT{1'b0}}};
    assign target_o = pc4_i + offs;
endmodule

// File: rtl/br_hazard.sv
module br_hazard #(
    parameter int unsigned RAW   = 5,
    parameter int unsigned SLOTS = 2
) (
    input  logic [RAW-1:0]   rs_i,
    input  logic [RAW-1:0]   rt_i,
    input  logic [SLOTS-1:0] load_i,
    input  logic [RAW-1:0]   dest_i [SLOTS],
    output logic             hazard_o
);
    logic [SLOTS-1:0] hit;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic live;
        assign live   = load_i[s] && (dest_i[s] != '0);
        assign hit[s] = live && ((dest_i[s] == rs_i) || (dest_i[s] == rt_i));

        // R7
        always_comb begin
            zero_dest_chk: assert (!((dest_i[s] == '0) && hit[s]));
        end
    end

    assign hazard_o = |hit;
endmodule

// File: rtl/br_ctrl.sv
module br_ctrl
    import br_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_branch_i,
    input  logic cond_i,
    input  logic hazard_i,
    output logic taken_o,
    output logic stall_o,
    output br_state_e state_o
);
    br_state_e state_q, state_d;
    logic      live_br;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        live_br = is_branch_i && (state_q != ST_BUBBLE);
        taken_o = live_br && !hazard_i && cond_i;
        stall_o = live_br && hazard_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_LDWAIT: begin
                if (stall_o)      state_d = ST_LDWAIT;
                else if (taken_o) state_d = ST_BUBBLE;
                else              state_d = ST_RUN;
            end
            ST_BUBBLE: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    assign state_o = state_q;

    // R8
    bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUBBLE) |-> (!taken_o && !stall_o));
    // R6
    stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall_o && taken_o));
endmodule

// File: rtl/id_branch_resolve.sv
module id_branch_resolve
    import br_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned RAW     = 5,
    parameter int unsigned INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] fetch_instr_i,
    input  logic [XLEN-1:0]    fetch_pc4_i,
    input  logic               is_beq_i,
    input  logic               is_bne_i,
    input  logic [XLEN-1:0]    opnd_a_i,
    input  logic [XLEN-1:0]    opnd_b_i,
    input  logic [XLEN-1:0]    pc_plus4_i,
    input  logic [XLEN-1:0]    imm_sext_i,
    input  logic [RAW-1:0]     rs_idx_i,
    input  logic [RAW-1:0]     rt_idx_i,
    input  logic               ex_load_i,
    input  logic [RAW-1:0]     ex_dest_i,
    input  logic               mem_load_i,
    input  logic [RAW-1:0]     mem_dest_i,
    output logic               taken_o,
    output logic [XLEN-1:0]    target_o,
    output logic               pc_sel_o,
    output logic               if_flush_o,
    output logic               stall_o,
    output logic [INSTR_W-1:0] ifid_instr_o,
    output logic [XLEN-1:0]    ifid_pc4_o
);
    localparam int unsigned SLOTS = N_LOAD_SLOTS;

    logic             cond, hazard, is_branch;
    logic [SLOTS-1:0] ld_vec;
    logic [RAW-1:0]   ld_dest [SLOTS];
    br_state_e        state;

    assign is_branch  = is_beq_i | is_bne_i;
    assign ld_vec     = {mem_load_i, ex_load_i};
    assign ld_dest[0] = ex_dest_i;
    assign ld_dest[1] = mem_dest_i;

    br_compare #(.XLEN(XLEN)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (opnd_a_i),
        .b_i    (opnd_b_i),
        .bne_i  (is_bne_i),
        .cond_o (cond)
    );

    br_target #(.XLEN(XLEN), .SHIFT(2)) u_tgt (
        .pc4_i    (pc_plus4_i),
        .imm_i    (imm_sext_i),
        .target_o (target_o)
    );

    br_hazard #(.RAW(RAW), .SLOTS(SLOTS)) u_haz (
        .rs_i     (rs_idx_i),
        .rt_i     (rt_idx_i),
        .load_i   (ld_vec),
        .dest_i   (ld_dest),
        .hazard_o (hazard)
    );

    br_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_branch_i (is_branch),
        .cond_i      (cond),
        .hazard_i    (hazard),
        .taken_o     (taken_o),
        .stall_o     (stall_o),
        .state_o     (state)
    );

    assign pc_sel_o   = taken_o;
    assign if_flush_o = taken_o;

    always_ff @(posedge clk) begin
        if (!rst_n || if_flush_o) begin
            ifid_instr_o <= '0;
            ifid_pc4_o   <= '0;
        end else if (!stall_o) begin
            ifid_instr_o <= fetch_instr_i;
            ifid_pc4_o   <= fetch_pc4_i;
        end
    end

    // R5
    flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_flush_o |=> ((ifid_instr_o == '0) && (ifid_pc4_o == '0)));
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> ($stable(ifid_instr_o) && $stable(ifid_pc4_o)));
    // R8
    bubble_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUBBLE) |-> (ifid_instr_o == '0));
endmodule

// File: tb/test_id_branch_resolve.sv
module test_id_branch_resolve;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_instr, fetch_pc4, opa, opb, pc4, imm;
    logic        beq, bne, exl, meml;
    logic [4:0]  rs, rt, exd, memd;
    logic        taken, pc_sel, flush, stall;
    logic [31:0] target, ifid_instr, ifid_pc4;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    id_branch_resolve i_id_branch_resolve (
        .clk(clk), .rst_n(rst_n),
        .fetch_instr_i(fetch_instr), .fetch_pc4_i(fetch_pc4),
        .is_beq_i(beq), .is_bne_i(bne), .opnd_a_i(opa), .opnd_b_i(opb),
        .pc_plus4_i(pc4), .imm_sext_i(imm), .rs_idx_i(rs), .rt_idx_i(rt),
        .ex_load_i(exl), .ex_dest_i(exd), .mem_load_i(meml), .mem_dest_i(memd),
        .taken_o(taken), .target_o(target), .pc_sel_o(pc_sel),
        .if_flush_o(flush), .stall_o(stall),
        .ifid_instr_o(ifid_instr), .ifid_pc4_o(ifid_pc4)
    );

    typedef struct {
        string       tag;
        logic        taken;
        logic        stall;
        logic [31:0] target;
        logic [31:0] instr;
        logic [31:0] pc4v;
    } exp_t;

    exp_t q[$];
    event ev_chk;

    logic [31:0] m_instr = '0, m_pc4 = '0;
    bit          m_bubble = 1'b0;

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic ibeq, input logic ibne,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] p4, input logic [31:0] im,
                         input logic [4:0] irs, input logic [4:0] irt,
                         input logic iexl, input logic [4:0] iexd,
                         input logic imeml, input logic [4:0] imemd,
                         input logic [31:0] finstr, input logic [31:0] fpc4);
        exp_t e;
        bit br, hz, eqv;
        @(negedge clk);
        beq = ibeq; bne = ibne; opa = a; opb = b; pc4 = p4; imm = im;
        rs = irs; rt = irt; exl = iexl; exd = iexd; meml = imeml; memd = imemd;
        fetch_instr = finstr; fetch_pc4 = fpc4;
        br  = (ibeq || ibne) && !m_bubble;
        hz  = (iexl && iexd != 0 && (iexd == irs || iexd == irt)) ||
              (imeml && imemd != 0 && (imemd == irs || imemd == irt));
        eqv = (a == b);
        e.tag    = tag;
        e.stall  = br && hz;
        e.taken  = br && !hz && (ibeq ? eqv : !eqv);
        e.target = p4 + (im << 2);
        e.instr  = m_instr;
        e.pc4v   = m_pc4;
        q.push_back(e);
        if (e.taken) begin
            m_instr = '0; m_pc4 = '0; m_bubble = 1'b1;
        end else begin
            m_bubble = 1'b0;
            if (!e.stall) begin m_instr = finstr; m_pc4 = fpc4; end
        end
        #1 -> ev_chk;
    endtask

    initial begin : monitor
        forever begin
            @(ev_chk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(taken == e.taken, {e.tag, " taken"}, 32'(taken), 32'(e.taken));
                check(pc_sel == e.taken && flush == e.taken, {e.tag, " R4 pc_sel/flush"},
                      {30'd0, pc_sel, flush}, {30'd0, e.taken, e.taken});
                check(stall == e.stall, {e.tag, " stall"}, 32'(stall), 32'(e.stall));
                check(target == e.target, {e.tag, " R3 target"}, target, e.target);
                check(ifid_instr == e.instr, {e.tag, " ifid_instr"}, ifid_instr, e.instr);
                check(ifid_pc4 == e.pc4v, {e.tag, " ifid_pc4"}, ifid_pc4, e.pc4v);
            end
        end
    end

    initial begin : watchdog
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        beq = 0; bne = 0; opa = 0; opb = 0; pc4 = 0; imm = 0;
        rs = 0; rt = 0; exl = 0; exd = 0; meml = 0; memd = 0;
        fetch_instr = 0; fetch_pc4 = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R9 reset state, R10 idle
        drive("R9 reset", 0,0, 0,0, 32'h100,0, 0,0, 0,0, 0,0, 32'hAAAA0001, 32'h104);
        // R1 equal operands taken, R4, R5 next cycle
        drive("R1 beq equal", 1,0, 32'h1234,32'h1234, 32'h104,32'h10, 1,2, 0,0, 0,0, 32'hAAAA0002, 32'h108);
        // R8 bubble ignores branch decode, R5 nop in IF/ID
        drive("R8 bubble", 1,0, 5,5, 32'h144,1, 1,2, 0,0, 0,0, 32'hAAAA0003, 32'h148);
        // R1 differ in MSB only
        drive("R1 msb diff", 1,0, 32'h80000000,0, 32'h148,3, 3,4, 0,0, 0,0, 32'hAAAA0004, 32'h14C);
        // R1 differ in bit 0 only
        drive("R1 lsb diff", 1,0, 32'h0F0F0F0F,32'h0F0F0F0E, 32'h14C,7, 3,4, 0,0, 0,0, 32'hAAAA0005, 32'h150);
        // R2 bne taken, R3 negative offset
        drive("R2 bne diff", 0,1, 32'h1,32'h2, 32'h150,32'hFFFFFFFC, 3,4, 0,0, 0,0, 32'hAAAA0006, 32'h154);
        drive("R5 post flush", 0,0, 0,0, 32'h140,0, 0,0, 0,0, 0,0, 32'hAAAA0007, 32'h144);
        // R2 bne with equal operands falls through
        drive("R2 bne equal", 0,1, 32'h77,32'h77, 32'h144,2, 3,4, 0,0, 0,0, 32'hAAAA0008, 32'h148);
        // R6 load in execute stage feeds rs
        drive("R6 ex load", 1,0, 9,9, 32'h148,4, 7,4, 1,7, 0,0, 32'hAAAA0009, 32'h14C);
        // R6 load moved to memory stage, still stalled
        drive("R6 mem load", 1,0, 9,9, 32'h148,4, 7,4, 0,0, 1,7, 32'hAAAA0009, 32'h14C);
        // load gone: resolves taken from wait state
        drive("R6 release", 1,0, 9,9, 32'h148,4, 7,4, 0,0, 0,0, 32'hAAAA0009, 32'h14C);
        drive("R5 bubble2", 0,0, 0,0, 32'h15C,0, 0,0, 0,0, 0,0, 32'hAAAA000A, 32'h160);
        // R7 register zero never stalls
        drive("R7 zero reg", 1,0, 1,2, 32'h160,5, 0,4, 1,0, 1,0, 32'hAAAA000B, 32'h164);
        // R7 non-load producer never stalls
        drive("R7 non-load", 1,0, 1,2, 32'h164,6, 8,4, 0,8, 0,8, 32'hAAAA000C, 32'h168);
        // R10 no branch decode with matching load
        drive("R10 no branch", 0,0, 3,3, 32'h168,1, 8,9, 1,8, 1,9, 32'hAAAA000D, 32'h16C);
        // R6 rt matches memory-stage load
        drive("R6 rt mem", 1,0, 3,4, 32'h16C,1, 5,9, 0,0, 1,9, 32'hAAAA000E, 32'h170);
        drive("R1 after wait", 1,0, 3,4, 32'h16C,1, 5,9, 0,0, 0,0, 32'hAAAA000E, 32'h170);
        drive("R9 tail", 0,0, 0,0, 32'h170,0, 0,0, 0,0, 0,0, 32'hAAAA000F, 32'h174);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule